// File: doc/BRIEF.md
# Debug Instruction-Injection Scan Controller

This block sits behind a JTAG-style test access port and lets a debugger push instructions into a halted core. It owns a 4-bit instruction register (IR), a chain-select register (SCREG) and a 32-bit instruction holding register (ITR). The ITR is loaded over the instruction chain. Once loaded, the held word goes to the core each time the TAP state machine enters Run-Test/Idle. Each entry produces a single-cycle issue strobe. The ITR does not need to be rescanned between issues.

Issue has four gates: the current IR operation, the selected chain, an execute-enable control bit, and the core handshake (core ready, and no sticky precise data-abort). A shortcut IR opcode makes the block act as if EXTEST and the instruction chain were selected, and leaves SCREG untouched. A later INTEST load therefore returns to whatever chain SCREG holds, with no new chain-select scan. A status chain can be captured. An INTEST capture of that chain sends a clear pulse to the sticky fault flags.

The TAP state machine is outside this block. Its state decodes arrive as strobes (shift-IR, update-IR, capture-DR, shift-DR, update-DR) and as a Run-Test/Idle level. The core, the status register contents and the data-transfer chain are also outside and are modelled as plain ports.

Top module: `dbg_inject_ctrl`

## Requirements
- R1: After reset, the current operation reads bypass (cur_op_o = 0), the selected chain reads 0, issue_o and sticky_clr_o are low, and issue_instr_o is zero.
- R2: At update-IR, the IR shift contents decode as follows: 4'h0 gives EXTEST (cur_op_o = 1), 4'hC gives INTEST (2), 4'h2 gives chain-select (3), and 4'hF or any opcode not listed gives bypass (0). IR bits shift in LSB first through tdi_i.
- R3: With the chain-select operation current, update-DR loads the 5 shifted bits (LSB first) into SCREG. cur_chain_o shows SCREG whenever the shortcut is not active.
- R4: Opcode 4'hD at update-IR makes cur_op_o read EXTEST and cur_chain_o read 4, and leaves SCREG unchanged. A following INTEST load makes cur_chain_o read SCREG again.
- R5: With EXTEST and chain 4 in effect, update-DR writes the 32 shifted bits (LSB first) into the ITR, which drives issue_instr_o.
- R6: issue_o pulses high for exactly one cycle, one cycle after Run-Test/Idle is entered, and stays low while the state is held. It fires only when the current operation is EXTEST or INTEST and the selected chain is 4 or 5.
- R7: When exec_en_i is low, entering Run-Test/Idle gives no issue pulse.
- R8: While core_ready_i is low or sticky_pabort_i is high, no issue pulse occurs and an ITR update-DR leaves issue_instr_o unchanged.
- R9: Each later entry into Run-Test/Idle issues the held ITR again without a rescan.
- R10: With INTEST and chain 1, capture-DR loads status_i into the chain, which shifts out LSB first on tdo_o. One cycle after that capture, sticky_clr_o pulses for a single cycle.
- R11: With bypass current, the data path is one bit long: a captured 0, followed by tdi_i delayed by one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | TAP-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tdi_i | input | 1 | Serial scan data in |
| shift_ir_i | input | 1 | Shift-IR state strobe |
| update_ir_i | input | 1 | Update-IR state strobe |
| capture_dr_i | input | 1 | Capture-DR state strobe |
| shift_dr_i | input | 1 | Shift-DR state strobe |
| update_dr_i | input | 1 | Update-DR state strobe |
| rti_i | input | 1 | High while the TAP is in Run-Test/Idle |
| exec_en_i | input | 1 | Execute-enable control bit |
| core_ready_i | input | 1 | Core can accept an instruction |
| sticky_pabort_i | input | 1 | Sticky precise data-abort flag |
| status_i | input | 32 | Status word captured on chain 1 |
| tdo_o | output | 1 | Serial scan data out |
| cur_op_o | output | 2 | Effective operation: 0 bypass, 1 EXTEST, 2 INTEST, 3 chain-select |
| cur_chain_o | output | 5 | Effective selected chain |
| issue_o | output | 1 | One-cycle instruction issue strobe |
| issue_instr_o | output | 32 | Held ITR contents |
| sticky_clr_o | output | 1 | Pulse that clears the sticky fault flags |

## Verification
The assertions rely on the TAP strobes behaving the way a real TAP state machine drives them. At most one of shift-IR, update-IR, capture-DR, shift-DR and update-DR is high in any cycle, and Run-Test/Idle is never asserted together with any of them. The directed stimulus raises each strobe on its own for whole cycles and keeps rti_i low during every scan. Core ready, the abort flag and the execute enable are changed only while no scan or Run-Test/Idle pass is in progress.

// File: rtl/dbg_inj_pkg.sv
package dbg_inj_pkg;
  localparam int IR_W    = 4;
  localparam int SCREG_W = 5;
  localparam int INSTR_W = 32;

  localparam logic [IR_W-1:0] OPC_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OPC_SCAN_N = 4'h2;
  localparam logic [IR_W-1:0] OPC_INTEST = 4'hC;
  localparam logic [IR_W-1:0] OPC_ITRSEL = 4'hD;
  localparam logic [IR_W-1:0] OPC_BYPASS = 4'hF;

  localparam logic [SCREG_W-1:0] CH_STATUS = 5'd1;
  localparam logic [SCREG_W-1:0] CH_ITR    = 5'd4;
  localparam logic [SCREG_W-1:0] CH_DTR    = 5'd5;

  typedef enum logic [1:0] {
    OP_BYPASS = 2'd0,
    OP_EXTEST = 2'd1,
    OP_INTEST = 2'd2,
    OP_SCAN_N = 2'd3
  } op_e;
endpackage

// File: rtl/dbg_ir_unit.sv
module dbg_ir_unit
  import dbg_inj_pkg::*;
#(
  parameter int IRW = IR_W,
  parameter int SW  = SCREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tdi_i,
  input  logic          shift_ir_i,
  input  logic          update_ir_i,
  input  logic [SW-1:0] screg_i,
  output op_e           op_o,
  output logic [SW-1:0] chain_o,
  output logic          ir_tdo_o
);
  logic [IRW-1:0] ir_sh;
  op_e            op_q;
  logic           itrsel_q;

  function automatic op_e decode(input logic [IRW-1:0] opc);
    case (opc)
      OPC_EXTEST: decode = OP_EXTEST;
      OPC_INTEST: decode = OP_INTEST;
      OPC_SCAN_N: decode = OP_SCAN_N;
      default:    decode = OP_BYPASS;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sh    <= OPC_BYPASS;
      op_q     <= OP_BYPASS;
      itrsel_q <= 1'b0;
    end else begin
      if (shift_ir_i) ir_sh <= {tdi_i, ir_sh[IRW-1:1]};
      if (update_ir_i) begin
        if (ir_sh == OPC_ITRSEL) begin
          // shortcut: behave as EXTEST on the ITR chain, SCREG untouched
          op_q     <= OP_EXTEST;
          itrsel_q <= 1'b1;
        end else begin
          op_q     <= decode(ir_sh);
          itrsel_q <= 1'b0;
        end
      end
    end
  end

  assign op_o     = op_q;
  assign chain_o  = itrsel_q ? CH_ITR : screg_i;
  assign ir_tdo_o = ir_sh[0];
endmodule

// File: rtl/dbg_dr_unit.sv
module dbg_dr_unit
  import dbg_inj_pkg::*;
#(
  parameter int DW = INSTR_W,
  parameter int SW = SCREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tdi_i,
  input  logic          capture_dr_i,
  input  logic          shift_dr_i,
  input  logic          update_dr_i,
  input  op_e           op_i,
  input  logic [SW-1:0] chain_i,
  input  logic [DW-1:0] status_i,
  input  logic          itr_wr_ok_i,
  output logic [SW-1:0] screg_o,
  output logic [DW-1:0] itr_o,
  output logic          dr_tdo_o,
  output logic          sticky_clr_o
);
  localparam int LW = $clog2(DW + 1);

  logic [DW-1:0] dr_sh, dr_nxt;
  logic [SW-1:0] screg_q;
  logic [DW-1:0] itr_q;
  logic          clr_q;
  logic [LW-1:0] len;
  logic          on_status, on_itr;

  assign on_status = (op_i == OP_EXTEST || op_i == OP_INTEST) && chain_i == CH_STATUS;
  assign on_itr    = (op_i == OP_EXTEST || op_i == OP_INTEST) && chain_i == CH_ITR;

  always_comb begin
    if (op_i == OP_SCAN_N)         len = LW'(SW);
    else if (on_status || on_itr)  len = LW'(DW);
    else                           len = LW'(1);
  end

  // variable-length shift: tdi enters at bit len-1, bits above are held
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      if (i == int'(len) - 1)     dr_nxt[i] = tdi_i;
      else if (i < int'(len) - 1) dr_nxt[i] = dr_sh[i+1];
      else                        dr_nxt[i] = dr_sh[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_sh   <= '0;
      screg_q <= '0;
      itr_q   <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= capture_dr_i && on_status && op_i == OP_INTEST;
      if (capture_dr_i) begin
        if (op_i == OP_SCAN_N) dr_sh <= DW'(screg_q);
        else if (on_status)    dr_sh <= status_i;
        else if (on_itr)       dr_sh <= itr_q;
        else                   dr_sh <= '0;
      end else if (shift_dr_i) begin
        dr_sh <= dr_nxt;
      end
      if (update_dr_i) begin
        if (op_i == OP_SCAN_N) screg_q <= dr_sh[SW-1:0];
        else if (on_itr && op_i == OP_EXTEST && itr_wr_ok_i) itr_q <= dr_sh;
      end
    end
  end

  assign screg_o      = screg_q;
  assign itr_o        = itr_q;
  assign dr_tdo_o     = dr_sh[0];
  assign sticky_clr_o = clr_q;
endmodule

// File: rtl/dbg_issue_unit.sv
module dbg_issue_unit
  import dbg_inj_pkg::*;
#(
  parameter int SW = SCREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rti_i,
  input  op_e           op_i,
  input  logic [SW-1:0] chain_i,
  input  logic          exec_en_i,
  input  logic          core_ready_i,
  input  logic          sticky_pabort_i,
  output logic          issue_o
);
  logic rti_q, issue_q, allowed, core_ok;

  assign core_ok = core_ready_i && !sticky_pabort_i;
  assign allowed = (op_i == OP_EXTEST || op_i == OP_INTEST) &&
                   (chain_i == CH_ITR || chain_i == CH_DTR) &&
                   exec_en_i && core_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rti_q   <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      rti_q   <= rti_i;
      issue_q <= rti_i && !rti_q && allowed;
    end
  end

  assign issue_o = issue_q;
endmodule

// File: rtl/dbg_inject_ctrl.sv
module dbg_inject_ctrl
  import dbg_inj_pkg::*;
#(
  parameter int DW = INSTR_W,
  parameter int SW = SCREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tdi_i,
  input  logic          shift_ir_i,
  input  logic          update_ir_i,
  input  logic          capture_dr_i,
  input  logic          shift_dr_i,
  input  logic          update_dr_i,
  input  logic          rti_i,
  input  logic          exec_en_i,
  input  logic          core_ready_i,
  input  logic          sticky_pabort_i,
  input  logic [DW-1:0] status_i,
  output logic          tdo_o,
  output logic [1:0]    cur_op_o,
  output logic [SW-1:0] cur_chain_o,
  output logic          issue_o,
  output logic [DW-1:0] issue_instr_o,
  output logic          sticky_clr_o
);
  op_e           op;
  logic [SW-1:0] chain, screg;
  logic          ir_tdo, dr_tdo;

  dbg_ir_unit #(.IRW(IR_W), .SW(SW)) u_ir (
    .clk_i, .rst_ni, .tdi_i, .shift_ir_i, .update_ir_i,
    .screg_i(screg), .op_o(op), .chain_o(chain), .ir_tdo_o(ir_tdo)
  );

  dbg_dr_unit #(.DW(DW), .SW(SW)) u_dr (
    .clk_i, .rst_ni, .tdi_i, .capture_dr_i, .shift_dr_i, .update_dr_i,
    .op_i(op), .chain_i(chain), .status_i,
    .itr_wr_ok_i(core_ready_i && !sticky_pabort_i),
    .screg_o(screg), .itr_o(issue_instr_o), .dr_tdo_o(dr_tdo),
    .sticky_clr_o
  );

  dbg_issue_unit #(.SW(SW)) u_iss (
    .clk_i, .rst_ni, .rti_i, .op_i(op), .chain_i(chain),
    .exec_en_i, .core_ready_i, .sticky_pabort_i, .issue_o
  );

  assign tdo_o       = shift_ir_i ? ir_tdo : dr_tdo;
  assign cur_op_o    = op;
  assign cur_chain_o = chain;
endmodule

// File: rtl/dbg_inject_ctrl_chk.sv
module dbg_inject_ctrl_chk #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          update_ir_i,
  input logic          capture_dr_i,
  input logic          update_dr_i,
  input logic          rti_i,
  input logic          exec_en_i,
  input logic          core_ready_i,
  input logic          sticky_pabort_i,
  input logic [SW-1:0] cur_chain_o,
  input logic          issue_o,
  input logic [DW-1:0] issue_instr_o,
  input logic          sticky_clr_o
);
  assert_issue_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);
  assert_issue_in_rti_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(rti_i));
  assert_issue_exec_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(exec_en_i));
  assert_issue_core_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ($past(core_ready_i) && !$past(sticky_pabort_i)));
  assert_itr_hold_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_dr_i && (!core_ready_i || sticky_pabort_i)) |=> $stable(issue_instr_o));
  assert_itr_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable(issue_instr_o));
  assert_chain_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_ir_i && !update_dr_i) |=> $stable(cur_chain_o));
  assert_clr_after_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_clr_o |-> $past(capture_dr_i));
  assert_clr_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_clr_o |=> !sticky_clr_o);
endmodule

bind dbg_inject_ctrl dbg_inject_ctrl_chk #(.DW(DW), .SW(SW)) u_chk (.*);

// File: tb/dbg_inject_ctrl_bench.sv
module dbg_inject_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tdi = 0, shift_ir = 0, update_ir = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic        rti = 0, exec_en = 0, core_ready = 1, sticky = 0;
  logic [31:0] status = 32'hA5C3_0F12;
  logic        tdo, issue, sticky_clr;
  logic [1:0]  cur_op;
  logic [4:0]  cur_chain;
  logic [31:0] instr;

  int checks = 0, errors = 0;
  logic clr_first, clr_later;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_inject_ctrl u_dbg_inject_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tdi_i(tdi), .shift_ir_i(shift_ir), .update_ir_i(update_ir),
    .capture_dr_i(capture_dr), .shift_dr_i(shift_dr), .update_dr_i(update_dr), .rti_i(rti),
    .exec_en_i(exec_en), .core_ready_i(core_ready), .sticky_pabort_i(sticky),
    .status_i(status), .tdo_o(tdo), .cur_op_o(cur_op), .cur_chain_o(cur_chain),
    .issue_o(issue), .issue_instr_o(instr), .sticky_clr_o(sticky_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ir(input logic [3:0] opc);
    @(negedge clk);
    shift_ir = 1;
    for (int i = 0; i < 4; i++) begin
      tdi = opc[i];
      @(negedge clk);
    end
    shift_ir = 0; update_ir = 1;
    @(negedge clk);
    update_ir = 0;
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    @(negedge clk);
    capture_dr = 1;
    @(negedge clk);
    capture_dr = 0; shift_dr = 1;
    clr_first = sticky_clr; clr_later = 0;
    for (int i = 0; i < len; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      if (i > 0) clr_later |= sticky_clr;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk);
    update_dr = 0;
  endtask

  task automatic rti_pass(input int hold, output int pulses);
    pulses = 0;
    @(negedge clk);
    rti = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      pulses += int'(issue);
    end
    rti = 0;
    @(negedge clk);
    pulses += int'(issue);
  endtask

  task automatic t_reset;
    check("R1 op", 32'(cur_op), 0);
    check("R1 chain", 32'(cur_chain), 0);
    check("R1 issue", 32'(issue), 0);
    check("R1 clr", 32'(sticky_clr), 0);
    check("R1 instr", instr, 0);
  endtask

  task automatic t_decode;
    load_ir(4'h0); check("R2 extest", 32'(cur_op), 1);
    load_ir(4'hC); check("R2 intest", 32'(cur_op), 2);
    load_ir(4'h2); check("R2 scan_n", 32'(cur_op), 3);
    load_ir(4'h7); check("R2 unknown", 32'(cur_op), 0);
    load_ir(4'hF); check("R2 bypass", 32'(cur_op), 0);
  endtask

  task automatic t_scan_n;
    logic [31:0] d;
    load_ir(4'h2);
    scan_dr(5, 32'd5, d);
    check("R3 chain", 32'(cur_chain), 5);
    load_ir(4'h0);
    check("R3 chain kept", 32'(cur_chain), 5);
  endtask

  task automatic t_itrsel_load;
    logic [31:0] d;
    load_ir(4'hD);
    check("R4 op", 32'(cur_op), 1);
    check("R4 chain", 32'(cur_chain), 4);
    scan_dr(32, 32'hEE00_0E15, d);
    check("R5 instr", instr, 32'hEE00_0E15);
    load_ir(4'hC);
    check("R4 restore chain", 32'(cur_chain), 5);
    check("R4 restore op", 32'(cur_op), 2);
  endtask

  task automatic t_issue;
    int p;
    exec_en = 1;
    rti_pass(4, p);
    check("R6 one pulse", 32'(p), 1);
    check("R6 instr", instr, 32'hEE00_0E15);
  endtask

  task automatic t_reissue;
    int p;
    rti_pass(1, p); check("R9 reissue 1", 32'(p), 1);
    rti_pass(2, p); check("R9 reissue 2", 32'(p), 1);
  endtask

  task automatic t_exec_off;
    int p;
    exec_en = 0;
    rti_pass(2, p); check("R7 no issue", 32'(p), 0);
    exec_en = 1;
  endtask

  task automatic t_blocked;
    int p;
    logic [31:0] d;
    core_ready = 0;
    rti_pass(2, p); check("R8 not ready", 32'(p), 0);
    core_ready = 1; sticky = 1;
    rti_pass(2, p); check("R8 sticky", 32'(p), 0);
    load_ir(4'hD);
    scan_dr(32, 32'h1234_5678, d);
    check("R8 itr held sticky", instr, 32'hEE00_0E15);
    sticky = 0; core_ready = 0;
    scan_dr(32, 32'h1234_5678, d);
    check("R8 itr held ready", instr, 32'hEE00_0E15);
    core_ready = 1;
    scan_dr(32, 32'h1234_5678, d);
    check("R5 itr written", instr, 32'h1234_5678);
    rti_pass(1, p); check("R6 issue extest ch4", 32'(p), 1);
  endtask

  task automatic t_gate_ir;
    int p;
    logic [31:0] d;
    load_ir(4'hF);
    rti_pass(1, p); check("R6 bypass no issue", 32'(p), 0);
    load_ir(4'h2);
    scan_dr(5, 32'd1, d);
    load_ir(4'hC);
    check("R3 chain 1", 32'(cur_chain), 1);
    rti_pass(1, p); check("R6 chain1 no issue", 32'(p), 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    scan_dr(32, 32'h0, d);
    check("R10 status out", d, 32'hA5C3_0F12);
    check("R10 clr pulse", 32'(clr_first), 1);
    check("R10 clr single", 32'(clr_later), 0);
  endtask

  task automatic t_bypass;
    logic [31:0] d;
    load_ir(4'hF);
    scan_dr(3, 32'b101, d);
    check("R11 bypass delay", d, 32'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_scan_n();
    t_itrsel_load();
    t_issue();
    t_reissue();
    t_exec_off();
    t_blocked();
    t_gate_ir();
    t_status();
    t_bypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule